// File: doc/BRIEF.md
# Multiplexed Latch Bank with Dual Enables

This block is a row of identical bit slices. Each slice picks one of two data bits and keeps the result in a level-sensitive storage element. Every slice shares one select input, two hold inputs and one asynchronous clear. The select input sets the source for all slices at the same moment. The two hold inputs are ORed together. While both are low the bank is transparent and the outputs follow the selected data with no clock involved. While either hold input is high, the outputs keep the value they had when the bank closed.

The clear input takes priority over everything else. While it is high, every output is low whatever the hold, select and data inputs are doing. The block is meant for capturing a data word from one of two sources under level control. An example is freezing a result bus while a downstream consumer reads it. There is no data handshake: the data inputs are plain levels, and the hold inputs give the only back-pressure. A word presented while the bank is holding is not stored and is not queued.

Top module: `mux_latch_bank`

## Requirements
- R1: The number of slices is the parameter `W`, which defaults to 6. Output bit i depends only on bit i of `src_a` and bit i of `src_b`, and never on any other bit position.
- R2: While the bank is transparent and clear is low, `pick_a` = 1 makes each output bit equal the matching bit of `src_a`.
- R3: While the bank is transparent and clear is low, `pick_a` = 0 makes each output bit equal the matching bit of `src_b`. The bank is transparent when `hold_x` = 0 and `hold_y` = 0, and the outputs then follow every change on the selected data without waiting for a clock.
- R4: While `hold_x` = 1, or `hold_y` = 1, or both, the outputs keep their last value whatever `src_a`, `src_b` and `pick_a` do.
- R5: While `clr` = 1, all outputs are 0. This takes effect at once, without waiting for a clock.
- R6: Clear overrides transparency. With `clr` = 1 and both hold inputs low, the outputs stay 0 even when the selected data is all ones.
- R7: If clear is released while the bank is transparent, the outputs take the currently selected data at once. If clear is released while the bank is holding, the outputs stay 0 until the bank next becomes transparent.
- R8: A change on `pick_a` while the bank is holding does not change the outputs. The newly selected data appears as soon as both hold inputs return low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | W | First data word, passed when `pick_a` = 1 |
| src_b | input | W | Second data word, passed when `pick_a` = 0 |
| pick_a | input | 1 | Shared source select |
| hold_x | input | 1 | First hold request, active high |
| hold_y | input | 1 | Second hold request, active high |
| clr | input | 1 | Asynchronous clear, active high, drives all outputs low |
| q_out | output | W | Stored word |

## Verification
The selection path is driven with complementary alternating words on the two sources, so that a swapped source or a crossed bit position shows up as a mismatch. All-ones and all-zeros words expose a stuck select. Each hold input is raised alone and then both together, and the data and the select are changed while the bank is closed. This separates an OR of the two holds from an AND, and shows whether anything leaks through a closed bank. Clear is exercised against open data and against a closed bank, and is then released in both states. This tells a true priority clear apart from a clear that only acts through the data path.

// File: rtl/mux_latch_bank_pkg.sv
package mux_latch_bank_pkg;

  localparam int unsigned DEF_WIDTH = 6;

  typedef enum logic {
    SRC_B = 1'b0,
    SRC_A = 1'b1
  } src_pick_e;

  typedef enum logic {
    BANK_OPEN   = 1'b0,
    BANK_CLOSED = 1'b1
  } bank_mode_e;

endpackage

// File: rtl/mlb_hold_merge.sv
module mlb_hold_merge
  import mux_latch_bank_pkg::*;
(
  input  logic       hold_x,
  input  logic       hold_y,
  output bank_mode_e mode
);

  always_comb begin
    if (hold_x || hold_y) mode = BANK_CLOSED;
    else                  mode = BANK_OPEN;
  end

endmodule

// File: rtl/mlb_slice.sv
module mlb_slice
  import mux_latch_bank_pkg::*;
(
  input  logic       bit_a,
  input  logic       bit_b,
  input  src_pick_e  pick,
  input  bank_mode_e mode,
  input  logic       clr,
  output logic       q
);

  logic chosen;

  always_comb begin
    case (pick)
      SRC_A:   chosen = bit_a;
      default: chosen = bit_b;
    endcase
  end

  always_latch begin
    if (clr)                    q <= 1'b0;
    else if (mode == BANK_OPEN) q <= chosen;
  end

endmodule

// File: rtl/mux_latch_bank.sv
module mux_latch_bank
  import mux_latch_bank_pkg::*;
#(
  parameter int unsigned W = DEF_WIDTH
) (
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         pick_a,
  input  logic         hold_x,
  input  logic         hold_y,
  input  logic         clr,
  output logic [W-1:0] q_out
);

  bank_mode_e mode;
  src_pick_e  pick;

  assign pick = src_pick_e'(pick_a);

  mlb_hold_merge u_merge (
    .hold_x (hold_x),
    .hold_y (hold_y),
    .mode   (mode)
  );

  for (genvar i = 0; i < W; i++) begin : g_slice
    mlb_slice u_slice (
      .bit_a (src_a[i]),
      .bit_b (src_b[i]),
      .pick  (pick),
      .mode  (mode),
      .clr   (clr),
      .q     (q_out[i])
    );
  end

endmodule

// File: rtl/mux_latch_bank_chk.sv
module mux_latch_bank_chk #(
  parameter int unsigned W = 6
) (
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         pick_a,
  input logic         hold_x,
  input logic         hold_y,
  input logic         clr,
  input logic [W-1:0] q_out
);

  logic open_w;
  assign open_w = !hold_x && !hold_y;

  always_comb begin
    if (clr) begin
      p_clear_low_r5: assert (q_out == '0)
        else $error("clear active but outputs not low");
    end
    if (clr && open_w) begin
      p_clear_wins_r6: assert (q_out == '0)
        else $error("transparent bank overrode clear");
    end
    if (!clr && open_w && pick_a) begin
      p_pick_a_r2: assert (q_out == src_a)
        else $error("transparent bank not showing source a");
    end
    if (!clr && open_w && !pick_a) begin
      p_pick_b_r3: assert (q_out == src_b)
        else $error("transparent bank not showing source b");
    end
  end

endmodule

bind mux_latch_bank mux_latch_bank_chk #(.W(W)) u_chk (
  .src_a  (src_a),
  .src_b  (src_b),
  .pick_a (pick_a),
  .hold_x (hold_x),
  .hold_y (hold_y),
  .clr    (clr),
  .q_out  (q_out)
);

// File: tb/mux_latch_bank_bench.sv
module mux_latch_bank_bench;

  localparam int W = 6;

  logic         clk = 1'b0;
  logic [W-1:0] src_a, src_b;
  logic         pick_a, hold_x, hold_y, clr;
  logic [W-1:0] q_out;
  int           total = 0;
  int           bad   = 0;
  bit           done  = 1'b0;
  logic [W-1:0] model_q;

  always #2.5 clk = ~clk;

  mux_latch_bank #(.W(W)) u_mux_latch_bank (
    .src_a  (src_a),
    .src_b  (src_b),
    .pick_a (pick_a),
    .hold_x (hold_x),
    .hold_y (hold_y),
    .clr    (clr),
    .q_out  (q_out)
  );

  // stimulus row: {clr, hold_x, hold_y, pick_a, src_a, src_b}
  localparam int NV = 18;
  localparam logic [15:0] VEC [NV] = '{
    {4'b0000, 6'b101010, 6'b010101},
    {4'b0001, 6'b101010, 6'b010101},
    {4'b0001, 6'b111111, 6'b000000},
    {4'b0000, 6'b111111, 6'b000000},
    {4'b0100, 6'b000000, 6'b110011},
    {4'b0101, 6'b011110, 6'b100001},
    {4'b0010, 6'b000111, 6'b111000},
    {4'b0011, 6'b111000, 6'b000111},
    {4'b0110, 6'b010101, 6'b101010},
    {4'b0111, 6'b000000, 6'b111111},
    {4'b0001, 6'b100001, 6'b011110},
    {4'b1001, 6'b111111, 6'b111111},
    {4'b1101, 6'b111111, 6'b111111},
    {4'b0101, 6'b111111, 6'b111111},
    {4'b0000, 6'b001100, 6'b110011},
    {4'b0010, 6'b111111, 6'b000000},
    {4'b0011, 6'b000000, 6'b111111},
    {4'b0001, 6'b000001, 6'b100000}
  };

  task automatic chk(input string req, input logic [W-1:0] exp);
    total++;
    if (q_out !== exp) begin
      bad++;
      $display("FAIL %s: q_out=%b expected=%b", req, q_out, exp);
    end
  endtask

  task automatic drive(input logic c, input logic hx, input logic hy,
                       input logic p, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    @(negedge clk);
    clr = c; hold_x = hx; hold_y = hy; pick_a = p; src_a = a; src_b = b;
    #1;
  endtask

  // behavioural reference taken from R2..R5
  task automatic model_step();
    if (clr)                  model_q = '0;
    else if (!hold_x && !hold_y) model_q = pick_a ? src_a : src_b;
  endtask

  initial begin
    clr = 1'b1; hold_x = 1'b0; hold_y = 1'b0; pick_a = 1'b1;
    src_a = '1; src_b = '1;
    model_q = '0;
    #1;
    chk("R5 reset state", '0);

    // table walk against the reference model
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12],
            VEC[i][11:6], VEC[i][5:0]);
      model_step();
      chk("R1/R2/R3/R4 table", model_q);
    end

    // R6: clear beats an open bank with all-ones data
    drive(1, 0, 0, 1, '1, '1);
    chk("R6 clear over open", '0);
    // R7: release while open -> selected data at once
    drive(0, 0, 0, 1, 6'b110110, 6'b001001);
    chk("R7 release open", 6'b110110);
    // R7: release while holding -> stays low until open
    drive(1, 1, 0, 1, 6'b110110, 6'b001001);
    chk("R5 clear over hold", '0);
    drive(0, 1, 0, 1, 6'b110110, 6'b001001);
    chk("R7 release closed", '0);
    drive(0, 0, 0, 0, 6'b110110, 6'b001001);
    chk("R7 reopen", 6'b001001);
    // R8: select flip while closed
    drive(0, 0, 1, 0, 6'b110110, 6'b001001);
    drive(0, 0, 1, 1, 6'b110110, 6'b001001);
    chk("R8 pick change held", 6'b001001);
    drive(0, 1, 1, 1, 6'b011011, 6'b100100);
    chk("R4 both holds", 6'b001001);
    drive(0, 0, 0, 1, 6'b011011, 6'b100100);
    chk("R8 new pick on open", 6'b011011);
    // R1: single-bit isolation
    drive(0, 0, 0, 0, 6'b111111, 6'b000100);
    chk("R1 bit isolation", 6'b000100);
    // R3: follow without clock while open
    @(negedge clk); src_b = 6'b100000; #0.5;
    chk("R3 follows mid-cycle", 6'b100000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule